// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core runs programs whose arithmetic names no operands. Add, subtract and multiply take the two entries at the top of an internal operand stack and put the result back on the stack. Only two instructions carry an address. Push copies a data-memory word onto the stack. Pop moves the top entry into a data-memory word. The core holds its own instruction memory and data memory, an eight-entry operand stack with a depth counter, and a control sequencer. Each instruction takes one fetch cycle and one execute cycle.

A host fills both memories through a load port while the core is idle. It then pulses `start`, and the core runs from instruction address 0. The core stops on a halt instruction. It also stops when a stack access would go past either end of the stack; in that case it raises a sticky error flag. Results are read back through a data-memory read port. Only reset leaves the halted state, and reset does not clear either memory.

Instructions are 16 bits wide. The opcode sits in bits [15:13] and the memory address in bits [4:0]. The opcodes are 0 halt, 1 push, 2 pop, 3 add, 4 subtract, 5 multiply. Codes 6 and 7 also halt.

Top module: `stack_core`

## Requirements
- R1: After reset, `busy`, `halted` and `err` are 0 and `depth` is 0.
- R2: Push (opcode 1) with address a places data word a on top of the stack and raises `depth` by one.
- R3: Pop (opcode 2) with address a writes the top entry into data word a and lowers `depth` by one.
- R4: Add (opcode 3) replaces the top two entries with their 16-bit wraparound sum.
- R5: Subtract (opcode 4) replaces the top two entries with top minus next, wrapping modulo 2^16.
- R6: Multiply (opcode 5) replaces the top two entries with the low 16 bits of their product.
- R7: An arithmetic instruction lowers `depth` by exactly one. A program of N instructions ending in halt raises `halted` 2N+1 clock edges after the edge that samples `start`.
- R8: Pop on an empty stack, or arithmetic with fewer than two entries, sets `err` and `halted` and leaves the stack depth and data memory unchanged.
- R9: Push while the stack holds 8 entries sets `err` and `halted`, and `depth` stays 8.
- R10: A halt instruction sets `halted` with `err` at 0. `halted` and `err` then hold until reset.
- R11: The program push E, push C, push D, mul, push B, add, sub, push F, add, push A, add, pop A leaves B+C*D-E+F+A in A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins execution at instruction 0 when idle |
| ld_imem_we | input | 1 | Writes `ld_wdata` into instruction memory |
| ld_dmem_we | input | 1 | Writes `ld_wdata` into data memory |
| ld_addr | input | 5 | Load port address |
| ld_wdata | input | 16 | Load port data |
| rd_addr | input | 5 | Data memory read address |
| rd_data | output | 16 | Data memory word at `rd_addr`, combinational |
| busy | output | 1 | Core is fetching or executing |
| halted | output | 1 | Core has stopped |
| err | output | 1 | Sticky stack overflow or underflow flag |
| depth | output | 4 | Number of stack entries |

## Verification
Each instruction takes a fetch edge and an execute edge, and both are counted. The bench therefore expects `halted` exactly 2N+1 edges after the edge that samples `start`. It counts edges from that point and samples 1 ns after each edge. Memory and depth results are read only after `halted` is seen. Because `rd_data` is combinational, a word is valid as soon as its address settles. Error cases are checked on the same edge as the halt, and are then rechecked a few cycles later to confirm that the flags hold.

// File: rtl/stack_core.sv
module stack_core #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_imem_we,
  input  logic          ld_dmem_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          halted,
  output logic          err,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int IW   = $clog2(DEPTH);
  localparam int MEMN = 1 << AW;
  localparam logic [1:0] S_IDLE = 2'd0, S_FETCH = 2'd1, S_EXEC = 2'd2, S_HALT = 2'd3;
  localparam logic [2:0] OP_PUSH = 3'd1, OP_POP = 3'd2, OP_ADD = 3'd3, OP_SUB = 3'd4, OP_MUL = 3'd5;

  logic [DW-1:0] imem [MEMN];
  logic [DW-1:0] dmem [MEMN];
  logic [DW-1:0] stk  [DEPTH];
  logic [1:0]    state;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;
  logic [SPW-1:0] sp, sp_m1, sp_m2;
  logic [DW-1:0] top, nxt, alu;
  logic [2:0]    op;
  logic [AW-1:0] opnd;
  logic          is_arith, exec, push_ok, pop_ok, arith_ok, fault;

  assign op       = ir[DW-1:DW-3];
  assign opnd     = ir[AW-1:0];
  assign sp_m1    = sp - SPW'(1);
  assign sp_m2    = sp - SPW'(2);
  assign top      = stk[sp_m1[IW-1:0]];
  assign nxt      = stk[sp_m2[IW-1:0]];
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  assign exec     = (state == S_EXEC);
  assign push_ok  = exec && op == OP_PUSH && sp < SPW'(DEPTH);
  assign pop_ok   = exec && op == OP_POP && sp != '0;
  assign arith_ok = exec && is_arith && sp >= SPW'(2);
  assign fault    = exec && ((op == OP_PUSH && !push_ok) || (op == OP_POP && !pop_ok) ||
                             (is_arith && !arith_ok));

  always_comb begin
    case (op)
      OP_ADD:  alu = top + nxt;
      OP_SUB:  alu = top - nxt;
      default: alu = top * nxt;
    endcase
  end

  always_ff @(posedge clk)
    if (ld_imem_we) imem[ld_addr] <= ld_wdata;

  always_ff @(posedge clk) begin
    if (ld_dmem_we) dmem[ld_addr] <= ld_wdata;
    if (pop_ok)     dmem[opnd] <= top;
  end

  always_ff @(posedge clk) begin
    if (push_ok)  stk[sp[IW-1:0]]    <= dmem[opnd];
    if (arith_ok) stk[sp_m2[IW-1:0]] <= alu;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
      ir    <= '0;
      sp    <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_FETCH;
          pc    <= '0;
        end
        S_FETCH: begin
          ir    <= imem[pc];
          pc    <= pc + AW'(1);
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          if (fault) begin
            err   <= 1'b1;
            state <= S_HALT;
          end else if (push_ok) sp <= sp + SPW'(1);
          else if (pop_ok || arith_ok) sp <= sp_m1;
          else state <= S_HALT;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign rd_data = dmem[rd_addr];
  assign busy    = (state == S_FETCH) || exec;
  assign halted  = (state == S_HALT);
  assign depth   = sp;
endmodule

module stack_core_chk #(
  parameter int DEPTH = 8,
  parameter int SPW   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           halted,
  input logic           err,
  input logic [SPW-1:0] depth,
  input logic [1:0]     state,
  input logic [2:0]     op
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SPW'(DEPTH));
  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && op == 3'd1 && depth < SPW'(DEPTH)) |=> depth == $past(depth) + SPW'(1));
  // R7
  arith_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && (op == 3'd3 || op == 3'd4 || op == 3'd5) && depth >= SPW'(2))
      |=> depth == $past(depth) - SPW'(1));
  // R8
  err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> halted && !busy);
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(err) && $stable(depth));
endmodule

bind stack_core stack_core_chk #(.DEPTH(DEPTH), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .halted(halted), .err(err),
  .depth(depth), .state(state), .op(op));

// File: tb/tb_stack_core.sv
module tb_stack_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [4:0]  ld_addr = '0, rd_addr = '0;
  logic [15:0] ld_wdata = '0;
  logic [15:0] rd_data;
  logic        busy, halted, err;
  logic [3:0]  depth;
  int          n_chk = 0, n_fail = 0;

  stack_core dut (.clk(clk), .rst_n(rst_n), .start(start), .ld_imem_we(ld_imem_we),
    .ld_dmem_we(ld_dmem_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .halted(halted), .err(err), .depth(depth));

  always #2.5 clk = ~clk;

  localparam logic [2:0] HLT = 3'd0, PSH = 3'd1, POP = 3'd2, ADD = 3'd3, SUB = 3'd4, MUL = 3'd5;

  // op, next (pushed first), top (pushed second), expected
  localparam logic [50:0] VEC [6] = '{
    {ADD, 16'd3,      16'd4,      16'd7},
    {SUB, 16'd3,      16'd10,     16'd7},
    {SUB, 16'd10,     16'd3,      16'hFFF9},
    {MUL, 16'd300,    16'd300,    16'h5F90},
    {ADD, 16'hFFFF,   16'd2,      16'd1},
    {MUL, 16'h0100,   16'h0100,   16'd0}
  };

  function automatic logic [15:0] enc(logic [2:0] o, int a);
    return {o, 8'd0, 5'(a)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wi(int a, logic [15:0] v);
    @(negedge clk); ld_imem_we = 1'b1; ld_addr = 5'(a); ld_wdata = v;
    @(negedge clk); ld_imem_we = 1'b0;
  endtask

  task automatic wd(int a, logic [15:0] v);
    @(negedge clk); ld_dmem_we = 1'b1; ld_addr = 5'(a); ld_wdata = v;
    @(negedge clk); ld_dmem_we = 1'b0;
  endtask

  task automatic run(output int cyc);
    @(negedge clk); start = 1'b1;
    cyc = 0;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1;
      start = 1'b0;
      cyc++;
      if (halted) break;
    end
    if (!halted) check(1'b0, "watchdog", cyc, 0);
  endtask

  task automatic rd(int a, output logic [15:0] v);
    rd_addr = 5'(a); #1; v = rd_data;
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] v;
    do_reset();
    #1;
    // R1
    check(!busy && !halted && !err && depth == 0, "R1", {busy, halted, err, depth}, 0);

    for (int i = 0; i < 6; i++) begin
      wd(0, VEC[i][47:32]); wd(1, VEC[i][31:16]); wd(2, 16'h0);
      wi(0, enc(PSH, 0)); wi(1, enc(PSH, 1)); wi(2, enc(VEC[i][50:48], 0));
      wi(3, enc(POP, 2)); wi(4, enc(HLT, 0));
      do_reset();
      run(cyc);
      rd(2, v);
      // R3 R4 R5 R6
      check(v == VEC[i][15:0], $sformatf("R4/R5/R6 vec%0d", i), v, VEC[i][15:0]);
      check(depth == 0 && !err, "R3 depth after pop", depth, 0);
    end

    // R2 and R7 depth after pushes
    wd(4, 16'hABCD);
    wi(0, enc(PSH, 4)); wi(1, enc(PSH, 4)); wi(2, enc(PSH, 4)); wi(3, enc(ADD, 0));
    wi(4, enc(POP, 5)); wi(5, enc(HLT, 0));
    do_reset(); run(cyc);
    check(depth == 1, "R2/R7 depth", depth, 1);
    rd(5, v);
    check(v == 16'h579A, "R2 pushed word sum", v, 16'h579A);

    // R11 R7 expression program and timing
    wd(10, 5); wd(11, 6); wd(12, 7); wd(13, 4); wd(14, 3); wd(15, 10);
    wi(0, enc(PSH, 13)); wi(1, enc(PSH, 11)); wi(2, enc(PSH, 12)); wi(3, enc(MUL, 0));
    wi(4, enc(PSH, 10)); wi(5, enc(ADD, 0)); wi(6, enc(SUB, 0)); wi(7, enc(PSH, 14));
    wi(8, enc(ADD, 0)); wi(9, enc(PSH, 15)); wi(10, enc(ADD, 0)); wi(11, enc(POP, 15));
    wi(12, enc(HLT, 0));
    do_reset(); run(cyc);
    rd(15, v);
    check(v == 16'd56, "R11 result", v, 56);
    check(cyc == 27, "R7 cycles", cyc, 27);
    check(!err && depth == 0, "R10 clean halt", err, 0);

    // R10 halt alone
    wi(0, enc(HLT, 0));
    do_reset(); run(cyc);
    check(cyc == 3 && halted && !err, "R10 halt timing", cyc, 3);
    repeat (4) @(posedge clk); #1;
    check(halted && !busy, "R10 halt holds", halted, 1);

    // R8 pop on empty
    wd(9, 16'h1234);
    wi(0, enc(POP, 9)); wi(1, enc(HLT, 0));
    do_reset(); run(cyc);
    rd(9, v);
    check(err && halted, "R8 pop empty err", err, 1);
    check(v == 16'h1234 && depth == 0, "R8 memory untouched", v, 16'h1234);

    // R8 arithmetic with one entry
    wi(0, enc(PSH, 9)); wi(1, enc(SUB, 0)); wi(2, enc(POP, 20)); wi(3, enc(HLT, 0));
    do_reset(); run(cyc);
    check(err && depth == 1 && cyc == 5, "R8 arith underflow", depth, 1);
    repeat (5) @(posedge clk); #1;
    check(err && halted, "R8 sticky err", err, 1);

    // R9 overflow
    for (int k = 0; k < 9; k++) wi(k, enc(PSH, 9));
    wi(9, enc(HLT, 0));
    do_reset(); run(cyc);
    check(err && halted && depth == 8, "R9 overflow", depth, 8);
    check(cyc == 19, "R9 halt edge", cyc, 19);

    do_reset(); #1;
    check(!err && !halted && depth == 0, "R1 reset clears err", err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule